// File: doc/BRIEF.md
# Streaming Echo Transmission Checker

This block confirms that a remote host has received the voter's selections intact. The terminal keeps the selections in a small local store of four byte slots, loaded through a plain write port. When confirmation starts, the host sends the selections back one byte per transfer. The checker compares each returned byte with the slot at the same position while the byte is still on the wire. It never keeps a copy of the returned stream.

A sticky mismatch flag records any disagreement. After the fourth returned byte the checker reports completion and a single pass/fail verdict. A synchronous clear restarts the comparison for a fresh confirmation and leaves the stored selections untouched. The store feeds the comparator over a dedicated path, not over any shared bus.

Top module: `tx_echo_verifier`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `check_done`, `tx_good` and `mismatch` are 0, the echo position is slot 0, and every slot of the store holds 8'h00.
- R2: A cycle with `wr_en` high writes `wr_data` into the slot addressed by `wr_addr` (0 to 3). The slot keeps that value until it is written again or `rst_n` goes low.
- R3: The n-th accepted echo byte since reset or clear (n = 0 to 3) is compared with slot n. A byte that differs from its own slot counts as a mismatch, even when it equals some other slot.
- R4: `mismatch` rises on the cycle after an accepted byte differs from its slot. It stays high until `clr` or reset, including before the sequence completes.
- R5: `check_done` rises on the cycle after the fourth accepted echo byte and not earlier. It stays high until `clr` or reset.
- R6: `tx_good` is high exactly when `check_done` is high and `mismatch` is low.
- R7: After `check_done` is high, echo bytes are ignored: `mismatch`, `check_done` and `tx_good` keep their values until `clr`.
- R8: `clr` returns the echo position to slot 0 and clears `check_done` and `mismatch` on the next cycle. It keeps the stored selections. An echo byte in the same cycle as `clr` is discarded.
- R9: A cycle with `echo_valid` low neither advances the echo position nor changes any flag, so idle gaps between echo bytes are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of flags, position and store |
| clr | input | 1 | Synchronous restart of a confirmation; keeps the store |
| wr_en | input | 1 | Write strobe for the selection store |
| wr_addr | input | 2 | Slot written when `wr_en` is high |
| wr_data | input | 8 | Selection byte to write |
| echo_valid | input | 1 | Qualifies `echo_byte` for one cycle |
| echo_byte | input | 8 | Byte returned by the host |
| check_done | output | 1 | All four echo bytes have been received |
| mismatch | output | 1 | Sticky: some echo byte differed from its slot |
| tx_good | output | 1 | Echo completed with no mismatch |

## Verification
The hardest case to reach from the ports is a disagreement at one particular position that is hidden among matching bytes. The bench runs one sequence per position with only that byte altered. It also sends a sequence that uses the correct values in the wrong order, which only position-tracked comparison rejects. The post-completion window, a clear that arrives together with a bad byte, and a slot rewritten between confirmations are each set up with their own directed sequences. Each of these is observed through the three flag outputs.

// File: rtl/echo_pkg.sv
package echo_pkg;
    localparam int unsigned CHOICE_W     = 8;
    localparam int unsigned CHOICE_SLOTS = 4;

    typedef enum logic {
        PH_COLLECT  = 1'b0,
        PH_FINISHED = 1'b1
    } chk_phase_e;
endpackage

// File: rtl/choice_store.sv
module choice_store #(
    parameter int unsigned W     = 8,
    parameter int unsigned N     = 4,
    localparam int unsigned AW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] slot_d [N];
    logic [W-1:0] slot_q [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_slot
        always_comb begin
            slot_d[gi] = slot_q[gi];
            if (wr_en && (wr_addr == AW'(gi))) begin
                slot_d[gi] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[gi] <= '0;
            end else begin
                slot_q[gi] <= slot_d[gi];
            end
        end
    end

    // Direct read path into the comparator
    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/byte_compare.sv
module byte_compare #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         differ
);
    logic [W-1:0] bit_diff;

    for (genvar gb = 0; gb < W; gb++) begin : g_bit
        assign bit_diff[gb] = lhs[gb] ^ rhs[gb];
    end

    assign differ = |bit_diff;
endmodule

// File: rtl/echo_tracker.sv
module echo_tracker
    import echo_pkg::*;
#(
    parameter int unsigned N   = 4,
    localparam int unsigned AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          echo_valid,
    input  logic          byte_differs,
    output logic [AW-1:0] cmp_idx,
    output logic          done,
    output logic          miss_seen
);
    localparam logic [AW-1:0] LAST_IDX = AW'(N - 1);

    typedef struct packed {
        logic [AW-1:0] idx;
        chk_phase_e    phase;
        logic          miss;
    } trk_t;

    trk_t st_d, st_q;
    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = echo_valid && (st_q.phase == PH_COLLECT);
        if (clr) begin
            st_d.idx   = '0;
            st_d.phase = PH_COLLECT;
            st_d.miss  = 1'b0;
        end else if (accept) begin
            if (byte_differs) begin
                st_d.miss = 1'b1;
            end
            if (st_q.idx == LAST_IDX) begin
                st_d.phase = PH_FINISHED;
                st_d.idx   = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, phase: PH_COLLECT, miss: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_idx   = st_q.idx;
    assign done      = (st_q.phase == PH_FINISHED);
    assign miss_seen = st_q.miss;
endmodule

// File: rtl/tx_echo_verifier.sv
module tx_echo_verifier
    import echo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       echo_valid,
    input  logic [7:0] echo_byte,
    output logic       check_done,
    output logic       mismatch,
    output logic       tx_good
);
    localparam int unsigned W  = CHOICE_W;
    localparam int unsigned N  = CHOICE_SLOTS;
    localparam int unsigned AW = (N > 1) ? $clog2(N) : 1;

    logic [AW-1:0] cmp_idx;
    logic [W-1:0]  stored_byte;
    logic          byte_differs;
    logic          done_w;
    logic          miss_w;

    choice_store #(.W(W), .N(N)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (cmp_idx),
        .rd_data (stored_byte)
    );

    byte_compare #(.W(W)) u_cmp (
        .lhs    (echo_byte),
        .rhs    (stored_byte),
        .differ (byte_differs)
    );

    echo_tracker #(.N(N)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .echo_valid   (echo_valid),
        .byte_differs (byte_differs),
        .cmp_idx      (cmp_idx),
        .done         (done_w),
        .miss_seen    (miss_w)
    );

    assign check_done = done_w;
    assign mismatch   = miss_w;
    assign tx_good    = done_w & ~miss_w;
endmodule

// File: rtl/tx_echo_verifier_chk.sv
module tx_echo_verifier_chk (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic echo_valid,
    input logic check_done,
    input logic mismatch,
    input logic tx_good
);
    AST_GOOD_MEANS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_good |-> (check_done && !mismatch)); // R6

    AST_DONE_CLEAN_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (check_done && !mismatch) |-> tx_good); // R6

    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !clr) |=> mismatch); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (check_done && !clr) |=> check_done); // R5

    AST_IGNORE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (check_done && !clr) |=> $stable(mismatch)); // R7

    AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!check_done && !mismatch)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!echo_valid && !clr) |=> ($stable(check_done) && $stable(mismatch))); // R9
endmodule

bind tx_echo_verifier tx_echo_verifier_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .echo_valid (echo_valid),
    .check_done (check_done),
    .mismatch   (mismatch),
    .tx_good    (tx_good)
);

// File: tb/tx_echo_verifier_tb.sv
module tx_echo_verifier_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       echo_valid = 1'b0;
    logic [7:0] echo_byte = '0;
    logic       check_done, mismatch, tx_good;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [7:0] ref_slot [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_echo_verifier u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .echo_valid(echo_valid), .echo_byte(echo_byte),
        .check_done(check_done), .mismatch(mismatch), .tx_good(tx_good)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_flags(input string req, input logic e_done, input logic e_miss);
        check(req, "check_done", check_done, e_done);
        check(req, "mismatch", mismatch, e_miss);
        check(req, "tx_good", tx_good, e_done & ~e_miss);
    endtask

    task automatic write_slot(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        ref_slot[a] = d;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        echo_valid = 1'b1; echo_byte = b;
        @(negedge clk);
        echo_valid = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1: reset state, store holds zeros
    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        check_flags("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        idle(1);
        check_flags("R1", 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) send_byte(8'h00);
        check_flags("R1", 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) ref_slot[i] = 8'h00;
    endtask

    // R2/R5/R6: loaded selections, exact echo
    task automatic t_match();
        write_slot(2'd0, 8'h3A);
        write_slot(2'd1, 8'hC5);
        write_slot(2'd2, 8'h07);
        write_slot(2'd3, 8'hE1);
        do_clear();
        for (int i = 0; i < 3; i++) begin
            send_byte(ref_slot[i]);
            check_flags("R5", 1'b0, 1'b0);
        end
        send_byte(ref_slot[3]);
        check_flags("R2", 1'b1, 1'b0);
        check("R6", "tx_good after clean echo", tx_good, 1'b1);
    endtask

    // R4: single wrong byte at each position
    task automatic t_mismatch_each();
        for (int p = 0; p < 4; p++) begin
            do_clear();
            for (int i = 0; i < 4; i++) begin
                send_byte(i == p ? (ref_slot[i] ^ 8'h10) : ref_slot[i]);
                if (i == p) check("R4", "mismatch right after bad byte", mismatch, 1'b1);
                if (i < 3) check("R4", "done before fourth", check_done, 1'b0);
            end
            check_flags("R4", 1'b1, 1'b1);
        end
    endtask

    // R3: right values in the wrong order
    task automatic t_order();
        do_clear();
        send_byte(ref_slot[1]);
        send_byte(ref_slot[0]);
        send_byte(ref_slot[2]);
        send_byte(ref_slot[3]);
        check_flags("R3", 1'b1, 1'b1);
    endtask

    // R9: idle gaps between bytes
    task automatic t_gaps();
        do_clear();
        for (int i = 0; i < 4; i++) begin
            idle(3);
            check("R9", "no done during gap", check_done, 1'b0);
            send_byte(ref_slot[i]);
        end
        idle(2);
        check_flags("R9", 1'b1, 1'b0);
    endtask

    // R7: bytes after completion ignored
    task automatic t_after_done();
        do_clear();
        for (int i = 0; i < 4; i++) send_byte(ref_slot[i]);
        check_flags("R7", 1'b1, 1'b0);
        send_byte(~ref_slot[0]);
        send_byte(8'hFF);
        check_flags("R7", 1'b1, 1'b0);
    endtask

    // R8: clear mid-stream and clear with simultaneous bad byte
    task automatic t_clear();
        do_clear();
        send_byte(~ref_slot[0]);
        check("R8", "mismatch before clear", mismatch, 1'b1);
        do_clear();
        check_flags("R8", 1'b0, 1'b0);
        @(negedge clk);
        clr = 1'b1; echo_valid = 1'b1; echo_byte = ~ref_slot[0];
        @(negedge clk);
        clr = 1'b0; echo_valid = 1'b0;
        check_flags("R8", 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) send_byte(ref_slot[i]);
        check_flags("R8", 1'b1, 1'b0);
    endtask

    // R2: rewrite one slot; new value expected, old value rejected
    task automatic t_rewrite();
        write_slot(2'd2, 8'h99);
        do_clear();
        for (int i = 0; i < 4; i++) send_byte(ref_slot[i]);
        check_flags("R2", 1'b1, 1'b0);
        do_clear();
        send_byte(ref_slot[0]);
        send_byte(ref_slot[1]);
        send_byte(8'h07);
        send_byte(ref_slot[3]);
        check_flags("R2", 1'b1, 1'b1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_match();
        t_mismatch_each();
        t_order();
        t_gaps();
        t_after_done();
        t_clear();
        t_rewrite();
        summary();
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end
endmodule